// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds one enable bit and one pending bit for each of a set of interrupt lines (32 by default). Software controls it over a simple word-wide register bus. Enable bits are changed only through two write-one registers, one that sets bits and one that clears them, and both return the same enable state on read. Pending bits are set by a high level on the matching input line, sampled at each rising clock edge, or by writing ones to a set-pending register. They are cleared by an acknowledge port that carries a line index.

The block drives a vector of the lines that are both pending and enabled. It also drives the index of the lowest-numbered such line with a valid flag. A line that is pending but disabled stays pending and is never presented as active. Priority levels, exception entry and nesting belong to logic outside this block.

Register byte offsets: 0x0 enable-set, 0x4 enable-clear, 0x8 pending-set. Any other offset is unmapped.

Top module: `irq_en_pend_bank`

## Requirements
- R1: After a clock edge with `rst_n` low, every enable and pending bit is 0, `irq_active` is all zero and `win_valid` is 0.
- R2: A write to offset 0x0 sets each enable bit whose data bit is 1 and leaves every enable bit whose data bit is 0 unchanged.
- R3: A write to offset 0x4 clears each enable bit whose data bit is 1 and leaves every enable bit whose data bit is 0 unchanged.
- R4: A read of offset 0x0 or 0x4 returns the enable state, with bit i set when line i is enabled. The value appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R5: A write to offset 0x8 sets each pending bit whose data bit is 1 and leaves the others unchanged. A 1 written to a bit that is already pending leaves it pending.
- R6: A read of offset 0x8 returns the pending state, with bit i set when line i is pending, using the same timing as R4.
- R7: A high level on `irq_in[i]` at a rising clock edge sets pending bit i, whether or not line i is enabled.
- R8: Bit i of `irq_active` is 1 exactly when line i is both pending and enabled. A pending line that is disabled never shows as active.
- R9: An acknowledge (`ack_valid` high with index `ack_idx`) clears that line's pending bit at the clock edge. If `irq_in` for that line is high in the same cycle, or the same cycle writes a 1 for it to offset 0x8, the bit stays pending.
- R10: When any line is active, `win_valid` is 1 and `win_idx` is the lowest active index. When no line is active, `win_valid` is 0.
- R11: A read of an unmapped offset returns 0, and a write to an unmapped offset changes no enable or pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data |
| irq_in | input | NUM_LINES (32) | Interrupt request lines, level sampled |
| ack_valid | input | 1 | Acknowledge request |
| ack_idx | input | IDX_W (5) | Line index whose pending bit is cleared |
| irq_active | output | NUM_LINES (32) | Lines that are pending and enabled |
| win_valid | output | 1 | At least one line is active |
| win_idx | output | IDX_W (5) | Lowest-numbered active line |

## Verification
A wrong enable or pending bit shows at once on `irq_active` and can move `win_idx` in the cycle after the edge that stored it. A read of the matching register exposes it one cycle after the request. A bit that is stuck pending while disabled stays hidden until the line is enabled, so the bench reads the pending register directly and also enables lines after pending them. An acknowledge that fails to clear a bit, or that overrides a same-cycle request, shows as a winner that persists or vanishes on the very next cycle.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
// Package irq_bank_pkg
// Shared register selector type and register byte offsets for the
// interrupt enable/pending bank. Offsets assume a bus address of at
// least 4 bits.
package irq_bank_pkg;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_EN_SET  = 2'd1,
        SEL_EN_CLR  = 2'd2,
        SEL_PND_SET = 2'd3
    } reg_sel_e;

    localparam logic [3:0] OFF_EN_SET  = 4'h0;
    localparam logic [3:0] OFF_EN_CLR  = 4'h4;
    localparam logic [3:0] OFF_PND_SET = 4'h8;

endpackage

// File: rtl/irq_bus_decode.sv
`timescale 1ns/1ps
// Module irq_bus_decode
// Turns a bus request into a register selector plus read and write
// strobes. Pure combinational logic. Assumes ADDR_W >= 4. Unmapped
// offsets decode to SEL_NONE.
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          reg_sel,
    output logic              wr_stb,
    output logic              rd_stb
);

    localparam int PAD_W = ADDR_W - 4;

    logic [ADDR_W-1:0] off_en_set;
    logic [ADDR_W-1:0] off_en_clr;
    logic [ADDR_W-1:0] off_pnd_set;

    generate
        if (PAD_W > 0) begin : g_pad
            assign off_en_set  = {{PAD_W{1'b0}}, OFF_EN_SET};
            assign off_en_clr  = {{PAD_W{1'b0}}, OFF_EN_CLR};
            assign off_pnd_set = {{PAD_W{1'b0}}, OFF_PND_SET};
        end else begin : g_nopad
            assign off_en_set  = OFF_EN_SET;
            assign off_en_clr  = OFF_EN_CLR;
            assign off_pnd_set = OFF_PND_SET;
        end
    endgenerate

    // Map the offset to a register selector.
    always_comb begin
        if (bus_addr == off_en_set)       reg_sel = SEL_EN_SET;
        else if (bus_addr == off_en_clr)  reg_sel = SEL_EN_CLR;
        else if (bus_addr == off_pnd_set) reg_sel = SEL_PND_SET;
        else                              reg_sel = SEL_NONE;
    end

    // Split the request into write and read strobes.
    always_comb begin
        wr_stb = bus_sel &  bus_wr;
        rd_stb = bus_sel & ~bus_wr;
    end

endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
// Module irq_enable_reg
// Holds one enable bit per line. The set and clear masks come from
// separate registers, so both are never nonzero in one cycle. Clear
// is applied after set, so clear would win if both were ever present.
module irq_enable_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_mask,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] en_q
);

    // Update enable bits from the write-one-to-set and write-one-to-clear masks.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/irq_pending_reg.sv
`timescale 1ns/1ps
// Module irq_pending_reg
// Holds one pending bit per line. A line level, or a software set,
// takes priority over an acknowledge that targets the same line in
// the same cycle.
module irq_pending_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_req,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] ack_mask,
    output logic [NUM_LINES-1:0] pend_q
);

    logic [NUM_LINES-1:0] pend_d;

    // Clear acknowledged bits first, then apply the set sources.
    always_comb pend_d = (pend_q & ~ack_mask) | line_req | sw_set;

    // Store the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
// Module irq_lowest_pick
// Combinational priority picker. Returns the lowest set index of req
// and a flag that is high when any bit is set. The index is 0 when
// no bit is set.
module irq_lowest_pick #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // Scan from the top down so that the lowest set bit is the last to write idx.
    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Flag the presence of any request.
    always_comb found = |req;

endmodule

// File: rtl/irq_en_pend_bank.sv
`timescale 1ns/1ps
// Module irq_en_pend_bank (top)
// Register bank with an enable bit and a pending bit per interrupt line,
// reached through a word-wide bus with registered read data. Drives the
// pending-and-enabled vector and the lowest active index.
// Assumes NUM_LINES <= BUS_W, ADDR_W >= 4 and a single bus master.
module irq_en_pend_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] irq_active,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx
);

    reg_sel_e             reg_sel;
    logic                 wr_stb;
    logic                 rd_stb;
    logic [NUM_LINES-1:0] wr_bits;
    logic [NUM_LINES-1:0] en_set_mask;
    logic [NUM_LINES-1:0] en_clr_mask;
    logic [NUM_LINES-1:0] pnd_set_mask;
    logic [NUM_LINES-1:0] ack_mask;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [BUS_W-1:0]     rd_word;

    irq_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .reg_sel (reg_sel),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    // Keep the write data bits that map to lines.
    always_comb wr_bits = bus_wdata[NUM_LINES-1:0];

    // Route the write data to the mask of the addressed register.
    always_comb begin
        en_set_mask  = (wr_stb && reg_sel == SEL_EN_SET)  ? wr_bits : '0;
        en_clr_mask  = (wr_stb && reg_sel == SEL_EN_CLR)  ? wr_bits : '0;
        pnd_set_mask = (wr_stb && reg_sel == SEL_PND_SET) ? wr_bits : '0;
    end

    // Decode the acknowledge index into a one-hot clear mask.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_ack
            assign ack_mask[g] = ack_valid && (ack_idx == IDX_W'(g));
        end
    endgenerate

    irq_enable_reg #(.NUM_LINES(NUM_LINES)) en_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(en_set_mask),
        .clr_mask(en_clr_mask),
        .en_q    (en_q)
    );

    irq_pending_reg #(.NUM_LINES(NUM_LINES)) pnd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_req(irq_in),
        .sw_set  (pnd_set_mask),
        .ack_mask(ack_mask),
        .pend_q  (pend_q)
    );

    // Combine pending and enable into the active vector.
    always_comb irq_active = pend_q & en_q;

    irq_lowest_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) pick_i (
        .req  (irq_active),
        .found(win_valid),
        .idx  (win_idx)
    );

    // Select the read word for the addressed register.
    always_comb begin
        rd_word = '0;
        case (reg_sel)
            SEL_EN_SET,
            SEL_EN_CLR:  rd_word[NUM_LINES-1:0] = en_q;
            SEL_PND_SET: rd_word[NUM_LINES-1:0] = pend_q;
            default:     rd_word = '0;
        endcase
    end

    // Register the read data on a read request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_stb) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/irq_bank_chk.sv
`timescale 1ns/1ps
// Module irq_bank_chk
// Property checker for irq_en_pend_bank, attached through bind. It
// observes the top-level ports and the stored enable and pending vectors.
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int BUS_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_idx,
    input logic [NUM_LINES-1:0] irq_active,
    input logic                 win_valid,
    input logic [IDX_W-1:0]     win_idx,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] pend_q
);

    logic [NUM_LINES-1:0] below_win;
    logic [NUM_LINES-1:0] wdata_lines;
    logic                 clr_write;

    always_comb below_win   = (NUM_LINES'(1) << win_idx) - NUM_LINES'(1);
    always_comb wdata_lines = bus_wdata[NUM_LINES-1:0];
    always_comb clr_write   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_EN_CLR));

    // R1: the first cycle after a reset edge shows nothing active.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_active == '0 && !win_valid));

    // R3: bits written as 1 to the clear register are disabled next cycle.
    assert_clear_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_write |=> ((en_q & $past(wdata_lines)) == '0));

    // R7: a high input line is pending in the next cycle.
    assert_line_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

    // R8: no disabled line is shown as active.
    assert_no_disabled_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active & ~en_q) == '0);

    // R9: an acknowledge with no competing set clears the pending bit.
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !irq_in[ack_idx] && !(bus_sel && bus_wr))
        |=> !pend_q[$past(ack_idx)]);

    // R10: the winner is active and no lower line is active.
    assert_winner_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (irq_active[win_idx] && (irq_active & below_win) == '0));

    // R10: the valid flag is low only when nothing is active.
    assert_valid_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (irq_active == '0));

endmodule

bind irq_en_pend_bank irq_bank_chk #(
    .NUM_LINES(NUM_LINES),
    .BUS_W    (BUS_W),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_in    (irq_in),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .irq_active(irq_active),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/irq_en_pend_bank_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies one cycle of stimulus at the
// falling edge, updates a reference model and queues expected results;
// the monitor compares them shortly after the next rising edge.
module irq_en_pend_bank_tb_top;

    localparam int N      = 32;
    localparam int AW     = 4;
    localparam int IW     = 5;
    localparam int KIND_RD  = 0;
    localparam int KIND_OUT = 1;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] vec;
        logic        vld;
        logic [4:0]  idx;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic [N-1:0]  irq_active;
    logic          win_valid;
    logic [IW-1:0] win_idx;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    logic [31:0] m_en = '0;
    logic [31:0] m_pend = '0;

    always #10 clk = ~clk;

    irq_en_pend_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .irq_active(irq_active), .win_valid(win_valid), .win_idx(win_idx)
    );

    task automatic push_out(input string tag);
        exp_t e;
        logic [31:0] act;
        act = m_en & m_pend;
        e.tag = tag; e.kind = KIND_OUT; e.vec = act; e.vld = |act; e.idx = '0;
        for (int i = 31; i >= 0; i--) if (act[i]) e.idx = 5'(i);
        exp_q.push_back(e);
    endtask

    // One clock of stimulus; model follows the requirements.
    task automatic drive(input string tag, input logic sel, input logic wr,
                         input logic [3:0] addr, input logic [31:0] wd,
                         input logic [31:0] irq, input logic av, input logic [4:0] ai);
        exp_t e;
        logic [31:0] ackm;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        irq_in = irq; ack_valid = av; ack_idx = ai;
        if (sel && !wr) begin
            e.tag = tag; e.kind = KIND_RD; e.vld = 1'b0; e.idx = '0;
            if (addr == 4'h0 || addr == 4'h4) e.vec = m_en;
            else if (addr == 4'h8)            e.vec = m_pend;
            else                              e.vec = '0;
            exp_q.push_back(e);
        end
        if (sel && wr && addr == 4'h0) m_en = m_en | wd;
        if (sel && wr && addr == 4'h4) m_en = m_en & ~wd;
        ackm = av ? (32'd1 << ai) : 32'd0;
        m_pend = (m_pend & ~ackm) | irq | ((sel && wr && addr == 4'h8) ? wd : 32'd0);
        push_out(tag);
    endtask

    task automatic wr_reg(input string tag, input logic [3:0] a, input logic [31:0] d);
        drive(tag, 1'b1, 1'b1, a, d, '0, 1'b0, '0);
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] a);
        drive(tag, 1'b1, 1'b0, a, '0, '0, 1'b0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Monitor: compare every queued item after the rising edge that produced it.
    always @(posedge clk) begin
        #5;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (e.kind == KIND_RD) begin
                if (bus_rdata !== e.vec) begin
                    n_errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", e.tag, bus_rdata, e.vec);
                end
            end else begin
                if (irq_active !== e.vec || win_valid !== e.vld || (e.vld && win_idx !== e.idx)) begin
                    n_errors++;
                    $display("FAIL %s: active/valid/idx actual=%h/%b/%0d expected=%h/%b/%0d",
                             e.tag, irq_active, win_valid, win_idx, e.vec, e.vld, e.idx);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    // Stimulus sequence.
    initial begin
        irq_in = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; irq_in = '0;
        // R1: state after reset is all clear.
        drive("R1", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        rd_reg("R1", 4'h0);
        rd_reg("R1", 4'h8);
        // R2: set enable bits, zeros leave others alone.
        wr_reg("R2", 4'h0, 32'h0000_00F0);
        rd_reg("R4", 4'h0);
        wr_reg("R2", 4'h0, 32'h0000_0000);
        rd_reg("R2", 4'h0);
        // R5 / R6: software pending set.
        wr_reg("R5", 4'h8, 32'h0000_0030);
        rd_reg("R6", 4'h8);
        wr_reg("R5", 4'h8, 32'h0000_0010);
        wr_reg("R5", 4'h8, 32'h0000_0000);
        rd_reg("R5", 4'h8);
        // R3 / R4: clear enable and read through both offsets.
        wr_reg("R3", 4'h4, 32'h0000_0010);
        rd_reg("R4", 4'h4);
        wr_reg("R3", 4'h4, 32'h0000_0000);
        rd_reg("R3", 4'h0);
        // R7 / R8: a disabled line becomes pending but not active.
        drive("R7", 1'b0, 1'b0, 4'h0, '0, 32'h0000_0004, 1'b0, '0);
        rd_reg("R7", 4'h8);
        drive("R8", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        wr_reg("R8", 4'h0, 32'h8000_0000);
        drive("R7", 1'b0, 1'b0, 4'h0, '0, 32'h8000_0000, 1'b0, '0);
        // R9 / R10: acknowledges and winner movement.
        drive("R9", 1'b0, 1'b0, 4'h0, '0, '0, 1'b1, 5'd5);
        drive("R10", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        drive("R9", 1'b0, 1'b0, 4'h0, '0, 32'h8000_0000, 1'b1, 5'd31);
        drive("R9", 1'b1, 1'b1, 4'h8, 32'h8000_0000, '0, 1'b1, 5'd31);
        drive("R9", 1'b0, 1'b0, 4'h0, '0, '0, 1'b1, 5'd31);
        drive("R10", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        // R8: enabling the disabled pending line makes it win.
        wr_reg("R8", 4'h0, 32'h0000_0004);
        // R11: unmapped offset.
        wr_reg("R11", 4'hC, 32'hFFFF_FFFF);
        rd_reg("R11", 4'hC);
        rd_reg("R11", 4'h0);
        rd_reg("R11", 4'h8);
        // R10: line 0 boundary.
        wr_reg("R10", 4'h0, 32'h0000_0001);
        drive("R10", 1'b0, 1'b0, 4'h0, '0, 32'h0000_0001, 1'b0, '0);
        // R1: reset in mid-run clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_en = '0; m_pend = '0;
        drive("R1", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        rd_reg("R1", 4'h4);
        drive("R1", 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);
        repeat (2) @(posedge clk);
        #8;
        finish_run();
    end

endmodule